// File: doc/BRIEF.md
# In-Order Cache-Line Read Engine

This block sits between a compute unit and a tagged, credit-controlled memory port. The compute unit posts read requests as a start address, a byte count and a stream number. Each request waits in a small queue until the engine turns it into a run of 128-byte line reads, one command per cycle at most. Every command carries a tag and a fixed read opcode that does not allocate in the intermediate cache.

Responses come back with their tag and may arrive in any order. A reorder buffer indexed by tag keeps each returning line until every older line has been passed on. The consumer then receives one 1024-bit beat per line, in the order the lines were requested. Each beat is marked valid and carries the stream number of the request it belongs to.

A tag is held from the cycle its command issues until its line is delivered. A credit is held from issue until the response arrives. Commands stop whenever either resource runs out.

Top module: `rd_line_dma`

## Requirements
- R1: After reset, `cmd_valid`, `out_valid` and `req_full` are low, and the full pool of `CREDITS` credits is available.
- R2: A request is taken at a clock edge where `req_valid` is high and `req_full` is low. `req_full` is high while `QDEPTH` (8) requests are held. A request offered while `req_full` is high is dropped and produces no command and no beat.
- R3: A request of `size` bytes produces ceil(size/128) commands. A request of size 0 produces none and is retired without stalling the requests behind it.
- R4: The k-th command of a request (k from 0) has `cmd_addr` = start address with bits 6..0 cleared, plus 128*k. Requests are issued in the order they were taken.
- R5: Every command carries `cmd_opcode` = 13'h0E00, the non-allocating line read.
- R6: At most one command issues per cycle. Commands issued minus responses received never exceeds `CREDITS`, and each response returns one credit.
- R7: Tags are handed out in sequence, 0, 1, ..., `TAGS`-1, and then wrap to 0. No more than `TAGS` lines are held between issue and delivery at any time.
- R8: Beats appear on `out_valid`/`out_data` in command order, whatever order the responses arrive in. Each `out_data` equals the `resp_data` returned for that line's tag. No beat is delivered while an older line is still missing.
- R9: Each beat's `out_stream` equals the `req_stream` of the request the line came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | 64 | Request start address |
| req_size | input | 32 | Request size in bytes |
| req_stream | input | SID_W | Request stream number |
| req_full | output | 1 | Request queue holds QDEPTH entries |
| cmd_valid | output | 1 | Line read command issues this cycle |
| cmd_tag | output | log2(TAGS) | Tag of the command |
| cmd_addr | output | 64 | Line address of the command |
| cmd_opcode | output | 13 | Read opcode of the command |
| resp_valid | input | 1 | Response for one tag, returns one credit |
| resp_tag | input | log2(TAGS) | Tag of the response |
| resp_data | input | DATA_W | Line data of the response |
| out_valid | output | 1 | Delivered beat present |
| out_stream | output | SID_W | Stream number of the beat |
| out_data | output | DATA_W | Line data of the beat |

## Verification
Two events often fall on the same clock edge: a credit coming back with a response, and a new command spending one. The credit count then has to stay unchanged rather than move twice. The bench provokes this with only six credits and a responder that answers every cycle, in oldest-first or newest-first order, so that issue and return overlap across long requests. The result is judged by counting outstanding commands against the credit limit, and by checking that stalls end at exactly six commands when responses are withheld. Delivery of a head line can also coincide with the arrival of a younger response; the in-order beat sequence, compared address by address with the expected line list, covers that case.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
    localparam int ADDR_W     = 64;
    localparam int SIZE_W     = 32;
    localparam int LINE_SHIFT = 7;
    localparam int LINES_W    = SIZE_W - LINE_SHIFT + 1;
    localparam int OPC_W      = 13;
    localparam logic [OPC_W-1:0] OPC_READ_NOALLOC = 13'h0E00;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [LINES_W-1:0] lines_t;

    typedef struct packed {
        addr_t  base;
        lines_t lines;
    } span_t;

    function automatic lines_t size_to_lines(input logic [SIZE_W-1:0] sz);
        logic [SIZE_W:0] t;
        t = {1'b0, sz} + (SIZE_W+1)'((1 << LINE_SHIFT) - 1);
        return lines_t'(t >> LINE_SHIFT);
    endfunction

    function automatic addr_t line_addr(input addr_t base, input lines_t idx);
        addr_t aligned;
        aligned = {base[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
        return aligned + (addr_t'(idx) << LINE_SHIFT);
    endfunction
endpackage

// File: rtl/rdl_req_queue.sv
module rdl_req_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[head];

    always_ff @(posedge clk) begin
        if (do_push) slots[tail] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (do_push) tail <= (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
            if (do_pop)  head <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/rdl_line_unroll.sv
module rdl_line_unroll
    import rdl_pkg::*;
#(
    parameter int CREDITS = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  head_valid,
    input  span_t head,
    input  logic  slot_free,
    input  logic  credit_ret,
    output logic  issue,
    output logic  pop,
    output addr_t cmd_addr
);
    localparam int CRED_W = $clog2(CREDITS + 1);

    logic [CRED_W-1:0] credits;
    lines_t            idx;
    logic              has_lines, last_line;

    assign has_lines = (head.lines != '0);
    assign last_line = (idx == head.lines - lines_t'(1));
    assign issue     = head_valid && has_lines && (credits != '0) && slot_free;
    assign pop       = head_valid && (!has_lines || (issue && last_line));
    assign cmd_addr  = line_addr(head.base, idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            credits <= CRED_W'(CREDITS);
            idx     <= '0;
        end else begin
            credits <= credits + CRED_W'(credit_ret) - CRED_W'(issue);
            if (pop)        idx <= '0;
            else if (issue) idx <= idx + lines_t'(1);
        end
    end

    // R6: the pool never grows past its size
    p_credit_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
        credits <= CRED_W'(CREDITS));
    // R6: a response only arrives for a command that spent a credit
    p_ret_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
        credit_ret |-> credits != CRED_W'(CREDITS));
    // R4: the next line of the same request lies one line further on
    p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && !pop) |=> cmd_addr == $past(cmd_addr) + addr_t'(1 << LINE_SHIFT));
endmodule

// File: rtl/rdl_reorder.sv
module rdl_reorder #(
    parameter int TAGS   = 32,
    parameter int DATA_W = 1024,
    parameter int SID_W  = 2,
    localparam int TAG_W = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [SID_W-1:0]  issue_sid,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              slot_free,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    input  logic [DATA_W-1:0] resp_data,
    output logic              out_valid,
    output logic [SID_W-1:0]  out_stream,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = $clog2(TAGS + 1);

    logic [DATA_W-1:0] line_mem [TAGS];
    logic [SID_W-1:0]  sid_mem  [TAGS];
    logic [TAGS-1:0]   landed;
    logic [TAG_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  used;
    logic              deliver;

    assign issue_tag = wr_ptr;
    assign slot_free = (used < CNT_W'(TAGS));
    assign deliver   = landed[rd_ptr];

    for (genvar g = 0; g < TAGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                landed[g] <= 1'b0;
            else if (resp_valid && resp_tag == TAG_W'(g))
                landed[g] <= 1'b1;
            else if (deliver && rd_ptr == TAG_W'(g))
                landed[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (resp_valid) line_mem[resp_tag] <= resp_data;
        if (issue)      sid_mem[wr_ptr]    <= issue_sid;
        if (deliver) begin
            out_data   <= line_mem[rd_ptr];
            out_stream <= sid_mem[rd_ptr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            used      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= deliver;
            if (issue)   wr_ptr <= (wr_ptr == TAG_W'(TAGS - 1)) ? '0 : wr_ptr + 1'b1;
            if (deliver) rd_ptr <= (rd_ptr == TAG_W'(TAGS - 1)) ? '0 : rd_ptr + 1'b1;
            used <= used + CNT_W'(issue) - CNT_W'(deliver);
        end
    end

    p_occupancy_r7: assert property (@(posedge clk) disable iff (rst)
        used <= CNT_W'(TAGS));
    p_issue_has_slot_r7: assert property (@(posedge clk) disable iff (rst)
        issue |-> used < CNT_W'(TAGS));
    p_resp_in_flight_r8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (!landed[resp_tag] && used != '0));
    p_beat_frees_slot_r8: assert property (@(posedge clk) disable iff (rst)
        deliver |=> !landed[$past(rd_ptr)]);
endmodule

// File: rtl/rd_line_dma.sv
module rd_line_dma
    import rdl_pkg::*;
#(
    parameter int SID_W   = 2,
    parameter int DATA_W  = 1024,
    parameter int QDEPTH  = 8,
    parameter int TAGS    = 32,
    parameter int CREDITS = 64,
    localparam int TAG_W  = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [31:0]       req_size,
    input  logic [SID_W-1:0]  req_stream,
    output logic              req_full,
    output logic              cmd_valid,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic [63:0]       cmd_addr,
    output logic [12:0]       cmd_opcode,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    input  logic [DATA_W-1:0] resp_data,
    output logic              out_valid,
    output logic [SID_W-1:0]  out_stream,
    output logic [DATA_W-1:0] out_data
);
    localparam int SPAN_W  = $bits(span_t);
    localparam int ENTRY_W = SID_W + SPAN_W;

    logic [ENTRY_W-1:0] q_din, q_dout;
    logic               q_empty, q_pop;
    span_t              in_span, head_span;
    logic [SID_W-1:0]   head_sid;
    logic               issue, slot_free;

    assign in_span   = '{base: req_addr, lines: size_to_lines(req_size)};
    assign q_din     = {req_stream, in_span};
    assign head_sid  = q_dout[ENTRY_W-1 -: SID_W];
    assign head_span = span_t'(q_dout[SPAN_W-1:0]);

    rdl_req_queue #(.W(ENTRY_W), .DEPTH(QDEPTH)) queue_i (
        .clk   (clk),
        .rst   (rst),
        .push  (req_valid),
        .din   (q_din),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (req_full)
    );

    rdl_line_unroll #(.CREDITS(CREDITS)) unroll_i (
        .clk        (clk),
        .rst        (rst),
        .head_valid (!q_empty),
        .head       (head_span),
        .slot_free  (slot_free),
        .credit_ret (resp_valid),
        .issue      (issue),
        .pop        (q_pop),
        .cmd_addr   (cmd_addr)
    );

    rdl_reorder #(.TAGS(TAGS), .DATA_W(DATA_W), .SID_W(SID_W)) rob_i (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .issue_sid  (head_sid),
        .issue_tag  (cmd_tag),
        .slot_free  (slot_free),
        .resp_valid (resp_valid),
        .resp_tag   (resp_tag),
        .resp_data  (resp_data),
        .out_valid  (out_valid),
        .out_stream (out_stream),
        .out_data   (out_data)
    );

    assign cmd_valid  = issue;
    assign cmd_opcode = OPC_READ_NOALLOC;

    // R1: nothing is issued or delivered in the cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !req_full));
endmodule

// File: tb/rd_line_dma_tb_top.sv
module rd_line_dma_tb_top;
    localparam int CRED  = 6;
    localparam int NTAGS = 32;
    localparam int WDOG  = 150000;

    typedef struct { logic [1:0] sid; logic [63:0] addr; } exp_t;
    typedef struct { int seq; logic [4:0] tag; logic [63:0] addr; } pend_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_size = '0;
    logic [1:0] req_stream = '0;
    logic req_full, cmd_valid, out_valid;
    logic [4:0] cmd_tag;
    logic [63:0] cmd_addr;
    logic [12:0] cmd_opcode;
    logic resp_valid = 1'b0;
    logic [4:0] resp_tag = '0;
    logic [1023:0] resp_data = '0;
    logic [1:0] out_stream;
    logic [1023:0] out_data;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int n_cmd = 0, n_resp = 0, n_out = 0;
    bit rsp_en = 0, rsp_lifo = 0, hold_on = 0;
    int hold_seq = 0;
    exp_t expq[$];
    pend_t pool[$];

    always #2 clk = ~clk;

    rd_line_dma #(.CREDITS(CRED)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_stream(req_stream), .req_full(req_full),
        .cmd_valid(cmd_valid), .cmd_tag(cmd_tag), .cmd_addr(cmd_addr),
        .cmd_opcode(cmd_opcode), .resp_valid(resp_valid), .resp_tag(resp_tag),
        .resp_data(resp_data), .out_valid(out_valid), .out_stream(out_stream),
        .out_data(out_data)
    );

    function automatic logic [1023:0] dfun(input logic [63:0] a);
        return {16{a ^ 64'h5A3C_0000_0000_0000}};
    endfunction

    function automatic void chk(input bit ok, input string rq,
                                input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            chk(0, "watchdog", cycles, WDOG);
            finish_run();
        end
    end

    // responder and command monitor
    always @(negedge clk) begin
        int pick;
        resp_valid = 1'b0;
        if (rsp_en && pool.size() > 0) begin
            pick = rsp_lifo ? pool.size() - 1 : 0;
            if (!(hold_on && pool[pick].seq == hold_seq)) begin
                resp_valid = 1'b1;
                resp_tag   = pool[pick].tag;
                resp_data  = dfun(pool[pick].addr);
                pool.delete(pick);
                n_resp++;
            end
        end
        if (cmd_valid && !rst) begin
            if (n_cmd < expq.size())
                chk(cmd_addr == expq[n_cmd].addr, "R4 cmd_addr", cmd_addr, expq[n_cmd].addr);
            else
                chk(0, "R2/R3 unexpected command", cmd_addr, 0);
            chk(cmd_opcode == 13'h0E00, "R5 opcode", cmd_opcode, 13'h0E00);
            chk(cmd_tag == 5'(n_cmd % NTAGS), "R7 tag order", cmd_tag, n_cmd % NTAGS);
            pool.push_back('{seq: n_cmd, tag: cmd_tag, addr: cmd_addr});
            n_cmd++;
            chk((n_cmd - n_resp) <= CRED, "R6 outstanding", n_cmd - n_resp, CRED);
        end
    end

    // beat monitor
    always @(negedge clk) begin
        if (out_valid && !rst) begin
            if (n_out < expq.size()) begin
                chk(out_stream == expq[n_out].sid, "R9 out_stream", out_stream, expq[n_out].sid);
                chk(out_data == dfun(expq[n_out].addr), "R8 out_data order",
                    out_data[63:0], dfun(expq[n_out].addr) & 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                chk(0, "R8 unexpected beat", n_out, expq.size());
            end
            n_out++;
        end
    end

    task automatic push(input logic [63:0] a, input logic [31:0] sz,
                        input logic [1:0] s, output bit acc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_stream = s;
        acc = !req_full;
        if (acc) begin
            for (longint k = 0; k < (longint'(sz) + 127) / 128; k++)
                expq.push_back('{sid: s, addr: {a[63:7], 7'b0} + 64'(k * 128)});
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string rq);
        int t = 0;
        while (n_out < expq.size() && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
        chk(n_out == expq.size(), rq, n_out, expq.size());
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 0, "R1 cmd_valid after reset", cmd_valid, 0);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(req_full == 0, "R1 req_full after reset", req_full, 0);
    endtask

    task automatic t_single();
        bit acc;
        int c0 = n_cmd;
        rsp_en = 1; rsp_lifo = 0;
        push(64'h0000_1000, 32'd128, 2'd1, acc);
        chk(acc, "R2 accept", acc, 1);
        drain("R8 single line delivered");
        chk(n_cmd - c0 == 1, "R3 one line", n_cmd - c0, 1);
    endtask

    task automatic t_rounding();
        bit acc;
        int c0 = n_cmd;
        rsp_en = 1; rsp_lifo = 0;
        push(64'h0000_2040, 32'd1,   2'd0, acc);
        push(64'h0000_3000, 32'd129, 2'd1, acc);
        push(64'h0000_4000, 32'd0,   2'd2, acc);
        push(64'h0000_5000, 32'd256, 2'd3, acc);
        push(64'h0000_6010, 32'd383, 2'd2, acc);
        drain("R3 rounded requests delivered");
        chk(n_cmd - c0 == 8, "R3 command count 1+2+0+2+3", n_cmd - c0, 8);
    endtask

    task automatic t_reorder();
        bit acc;
        rsp_en = 1; rsp_lifo = 1;
        push(64'h0001_0000, 32'd640, 2'd1, acc);
        push(64'h0002_0000, 32'd384, 2'd2, acc);
        push(64'h0003_0000, 32'd512, 2'd3, acc);
        drain("R8 newest-first responses delivered in order");
        rsp_lifo = 0;
    endtask

    task automatic t_credit_stall();
        bit acc;
        int c0 = n_cmd;
        rsp_en = 0;
        push(64'h0004_0000, 32'd1536, 2'd0, acc);
        repeat (40) @(negedge clk);
        chk(n_cmd - c0 == CRED, "R6 stall at credit limit", n_cmd - c0, CRED);
        chk(cmd_valid == 0, "R6 no command without credit", cmd_valid, 0);
        chk(out_valid == 0, "R8 nothing before response", out_valid, 0);
        rsp_en = 1;
        drain("R6 credits returned and request completed");
    endtask

    task automatic t_tag_stall();
        bit acc;
        int c0 = n_cmd;
        int o0 = n_out;
        rsp_en = 1; rsp_lifo = 1; hold_seq = n_cmd; hold_on = 1;
        push(64'h0008_0000, 32'd5120, 2'd2, acc);
        repeat (300) @(negedge clk);
        chk(n_cmd - c0 == NTAGS, "R7 stall at tag limit", n_cmd - c0, NTAGS);
        chk(n_out == o0, "R8 held head blocks delivery", n_out, o0);
        hold_on = 0;
        drain("R7 all forty lines delivered after release");
        rsp_lifo = 0;
    endtask

    task automatic t_queue_full();
        bit acc;
        int e0;
        rsp_en = 0;
        push(64'h0010_0000, 32'd1280, 2'd1, acc);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            push(64'h0020_0000 + 64'(i * 4096), 32'd128, 2'(i), acc);
            chk(acc, "R2 accept below depth", acc, 1);
        end
        @(negedge clk);
        chk(req_full == 1, "R2 full at eight entries", req_full, 1);
        e0 = expq.size();
        push(64'h0030_0000, 32'd128, 2'd3, acc);
        chk(!acc, "R2 offered while full", acc, 0);
        chk(expq.size() == e0, "R2 dropped request adds no lines", expq.size(), e0);
        rsp_en = 1;
        drain("R2 only accepted requests delivered");
        chk(req_full == 0, "R2 full clears", req_full, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_rounding();
        t_reorder();
        t_credit_stall();
        t_tag_stall();
        t_queue_full();
        chk(n_resp == n_cmd, "R6 every command answered", n_resp, n_cmd);
        finish_run();
    end
endmodule